// File: doc/BRIEF.md
# Interrupt Priority Byte File with Security-Filtered Access

This block holds one 8-bit priority value for every shared interrupt of an interrupt controller and exposes the whole set, flattened, to the selection logic that ranks pending interrupts. Software reaches the values through a 1024-byte register window in which the byte offset is the interrupt number, so a byte access touches one priority and an aligned 32-bit access touches four neighbours. The first 32 interrupt numbers are banked elsewhere, and numbers at or above the implemented count do not exist. Both ranges read as zero and ignore writes.

Every access carries a non-secure attribute. When security is enabled, a non-secure access may only touch interrupts whose group bit is set, and it sees a halved priority range: reads return the stored value shifted left by one, and writes store the written value shifted right by one with the top bit forced to one. This keeps non-secure software in the lower-urgency half of the scale. Secure accesses, and all accesses while security is disabled, see the raw byte. The group bits are owned by another block and arrive as an input vector.

The request is sampled on a clock edge. Writes take effect at that edge, and a response with read data follows one cycle later. No access ever produces a bus error.

Top module: `prio_view_regs`

## Requirements
- R1: Reset clears every stored priority to zero and holds the response valid low.
- R2: The request size code 0 means one byte at offset N, for interrupt N, with data in bits 7:0. Code 2 means a 32-bit access at a 4-aligned offset N that covers interrupts N to N+3, with interrupt N in bits 7:0 and N+3 in bits 31:24.
- R3: A secure access, or any access while the security-disable input is high, reads and writes the stored byte unchanged.
- R4: A non-secure access while security is enabled treats an interrupt whose group bit is 0 as read-as-zero, and the write leaves its stored value unchanged.
- R5: A non-secure read, with security enabled, of an interrupt whose group bit is 1 returns the stored value shifted left by one and truncated to 8 bits.
- R6: A non-secure write, with security enabled, to an interrupt whose group bit is 1 stores 0x80 ORed with the written byte shifted right by one.
- R7: A 32-bit write is discarded in all four bytes when its first interrupt is below 32 or its fourth is at or beyond the implemented count. A 32-bit read returns zero in each byte whose interrupt is out of range.
- R8: A byte access to an interrupt below 32 or at or beyond the implemented count reads zero and changes nothing.
- R9: Size code 1 (16-bit), size code 3, and 32-bit accesses whose offset is not a multiple of four are reserved. They read zero, change nothing and raise no error.
- R10: Within one 32-bit non-secure access, each of the four bytes is checked against its own group bit.
- R11: A request produces a response one cycle later, and no response otherwise. A write is visible on the priority output right after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqSize | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| reqAddr | input | 10 | Byte offset inside the priority window |
| reqNonSec | input | 1 | Request issued by non-secure software |
| reqWdata | input | 32 | Write data |
| secDisable | input | 1 | Security disabled: all accesses see raw values |
| groupBits | input | NUM_IRQ | Per-interrupt group bit, 1 means non-secure group |
| rspValid | output | 1 | Response for the request of the previous cycle |
| rspRdata | output | 32 | Read data; zero for writes and reserved accesses |
| prioFlat | output | NUM_IRQ*8 | Priority of interrupt i in bits 8i+7 to 8i |

## Verification
The assertions assume that the group bits and the security-disable input stay steady through the cycle in which a request is sampled, because the lane filter and the view translation are evaluated from them combinationally. They also assume that NUM_IRQ lies between 33 and 1020, so that every in-range lane index fits in the window. The stimulus holds both inputs constant for a whole request and changes them only between requests. It uses an implemented count of 62, which places the upper range limit inside a 32-bit word.

// File: rtl/prio_view_pkg.sv
package prio_view_pkg;

  localparam int LANES        = 4;
  localparam int WIN_AW       = 10;
  localparam int FIRST_SHARED = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // strobes from the access control to the storage datapath
  typedef struct packed {
    logic                        access;
    logic                        rdEn;
    logic                        nsView;
    logic [WIN_AW-1:0]           base;
    logic [LANES-1:0]            laneWr;
    logic [LANES-1:0]            laneRd;
    logic [LANES-1:0][7:0]       laneData;
  } prioStrobe_t;

endpackage

// File: rtl/prio_access_ctrl.sv
module prio_access_ctrl
  import prio_view_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [1:0]              reqSize,
  input  logic [WIN_AW-1:0]       reqAddr,
  input  logic                    reqNonSec,
  input  logic [31:0]             reqWdata,
  input  logic                    secDisable,
  input  logic [NUM_IRQ-1:0]      groupBits,
  output prioStrobe_t             strb
);

  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [WIN_AW:0] LO_LIM = (WIN_AW+1)'(FIRST_SHARED);
  localparam logic [WIN_AW:0] HI_LIM = (WIN_AW+1)'(NUM_IRQ);

  accSize_e          sizeCode;
  logic              nsView;
  logic [LANES-1:0]  laneUsed;
  logic [LANES-1:0]  laneInRange;
  logic [LANES-1:0]  laneGrpOk;
  logic              allUsedInRange;

  assign sizeCode = accSize_e'(reqSize);
  assign nsView   = reqNonSec && !secDisable;

  // which lanes a request size touches; reserved shapes touch none
  always_comb begin
    laneUsed = '0;
    unique case (sizeCode)
      SZ_BYTE: laneUsed = 4'b0001;
      SZ_WORD: laneUsed = (reqAddr[1:0] == 2'b00) ? 4'b1111 : 4'b0000;
      default: laneUsed = 4'b0000;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WIN_AW:0] laneIdx;
    logic [IW-1:0]   laneIdxClip;

    assign laneIdx        = {1'b0, reqAddr} + (WIN_AW+1)'(l);
    assign laneInRange[l] = (laneIdx >= LO_LIM) && (laneIdx < HI_LIM);
    assign laneIdxClip    = laneInRange[l] ? laneIdx[IW-1:0] : '0;
    assign laneGrpOk[l]   = !nsView || groupBits[laneIdxClip];

    assign strb.laneData[l] = nsView ? {1'b1, reqWdata[8*l+1 +: 7]}
                                     : reqWdata[8*l +: 8];
  end

  // a word write is all-or-nothing on range
  assign allUsedInRange = &(laneInRange | ~laneUsed);

  assign strb.access = reqValid;
  assign strb.rdEn   = reqValid && !reqWrite;
  assign strb.nsView = nsView;
  assign strb.base   = reqAddr;
  assign strb.laneRd = {LANES{reqValid && !reqWrite}} & laneUsed & laneInRange & laneGrpOk;
  assign strb.laneWr = {LANES{reqValid && reqWrite && allUsedInRange}}
                       & laneUsed & laneInRange & laneGrpOk;

  // reserved shapes never reach storage
  p_rsvd_inert_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqSize == 2'd1 || reqSize == 2'd3)) |-> (strb.laneWr == '0 && strb.laneRd == '0));

  p_misalign_inert_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd2 && reqAddr[1:0] != 2'b00) |-> (strb.laneWr == '0));

  // a word starting in the banked range is dropped entirely
  p_word_low_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == 2'd2 && reqAddr < WIN_AW'(FIRST_SHARED)) |-> (strb.laneWr == '0));

  // a non-secure translated write always lands in the upper half
  p_ns_top_bit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.nsView && (strb.laneWr != '0)) |-> (strb.laneData[0][7] && strb.laneData[3][7]));

  // secure-group byte is not reachable by non-secure software
  p_hidden_byte_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqNonSec && !secDisable && reqSize == 2'd0 && laneInRange[0]
     && !groupBits[g_lane[0].laneIdxClip]) |-> (!strb.laneWr[0] && !strb.laneRd[0]));

  // no lane can be both read and written
  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.laneWr & strb.laneRd) == '0);

endmodule

// File: rtl/prio_store_dp.sv
module prio_store_dp
  import prio_view_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  prioStrobe_t             strb,
  output logic [NUM_IRQ*8-1:0]    prioFlat,
  output logic                    rspValid,
  output logic [31:0]             rspRdata
);

  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  // storage: banked entries are tied to zero, shared entries are registers
  for (genvar e = 0; e < NUM_IRQ; e++) begin : g_entry
    if (e < FIRST_SHARED) begin : g_banked
      assign prioFlat[8*e +: 8] = 8'h00;
    end else begin : g_shared
      logic       hit;
      logic [7:0] nxtVal;
      logic [7:0] curVal;

      always_comb begin
        hit    = 1'b0;
        nxtVal = curVal;
        for (int l = 0; l < LANES; l++) begin
          if (strb.laneWr[l] &&
              (({1'b0, strb.base} + (WIN_AW+1)'(l)) == (WIN_AW+1)'(e))) begin
            hit    = 1'b1;
            nxtVal = strb.laneData[l];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN)    curVal <= 8'h00;
        else if (hit) curVal <= nxtVal;
      end

      assign prioFlat[8*e +: 8] = curVal;
    end
  end

  // read assembly, one byte lane at a time
  logic [31:0] rdWord;

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    logic [WIN_AW:0] rdIdx;
    logic [IW-1:0]   rdIdxClip;
    logic [7:0]      rawByte;

    assign rdIdx     = {1'b0, strb.base} + (WIN_AW+1)'(l);
    assign rdIdxClip = strb.laneRd[l] ? rdIdx[IW-1:0] : '0;
    assign rawByte   = strb.laneRd[l] ? prioFlat[{rdIdxClip, 3'b000} +: 8] : 8'h00;
    assign rdWord[8*l +: 8] = strb.nsView ? {rawByte[6:0], 1'b0} : rawByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= 32'h0;
    end else begin
      rspValid <= strb.access;
      rspRdata <= strb.rdEn ? rdWord : 32'h0;
    end
  end

  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.access |=> rspValid);

  p_no_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.access |=> !rspValid);

  // nothing changes in storage without a lane write strobe
  p_store_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.laneWr == '0) |=> $stable(prioFlat));

  p_wr_rsp_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.access && !strb.rdEn) |=> (rspRdata == 32'h0));

  // a translated read never has its lowest bit set in any lane
  p_ns_read_lsb_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.nsView) |=> (rspRdata[0] == 1'b0 && rspRdata[8] == 1'b0 &&
                                    rspRdata[16] == 1'b0 && rspRdata[24] == 1'b0));

  // a lane hidden from a read comes back as zero
  p_lane0_hidden_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !strb.laneRd[0]) |=> (rspRdata[7:0] == 8'h00));

endmodule

// File: rtl/prio_view_regs.sv
module prio_view_regs
  import prio_view_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [1:0]              reqSize,
  input  logic [9:0]              reqAddr,
  input  logic                    reqNonSec,
  input  logic [31:0]             reqWdata,
  input  logic                    secDisable,
  input  logic [NUM_IRQ-1:0]      groupBits,
  output logic                    rspValid,
  output logic [31:0]             rspRdata,
  output logic [NUM_IRQ*8-1:0]    prioFlat
);

  prioStrobe_t strb;

  prio_access_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqAddr    (reqAddr),
    .reqNonSec  (reqNonSec),
    .reqWdata   (reqWdata),
    .secDisable (secDisable),
    .groupBits  (groupBits),
    .strb       (strb)
  );

  prio_store_dp #(.NUM_IRQ(NUM_IRQ)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .prioFlat (prioFlat),
    .rspValid (rspValid),
    .rspRdata (rspRdata)
  );

endmodule

// File: tb/prio_view_regs_bench.sv
module prio_view_regs_bench;

  localparam int NIRQ = 62;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqWrite;
  logic [1:0]        reqSize;
  logic [9:0]        reqAddr;
  logic              reqNonSec;
  logic [31:0]       reqWdata;
  logic              secDisable;
  logic [NIRQ-1:0]   groupBits;
  logic              rspValid;
  logic [31:0]       rspRdata;
  logic [NIRQ*8-1:0] prioFlat;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prio_view_regs #(.NUM_IRQ(NIRQ)) u_prio_view_regs (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqNonSec(reqNonSec),
    .reqWdata(reqWdata), .secDisable(secDisable), .groupBits(groupBits),
    .rspValid(rspValid), .rspRdata(rspRdata), .prioFlat(prioFlat)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  size;
    logic        ns;
    logic        sd;
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  // group bits: 32..39 set, 40..47 clear, 48..55 = 0x5A, 60..61 set
  localparam logic [NIRQ-1:0] GRP = 62'h305A00FF_00000000;

  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'd2, 1'b0, 1'b0, 10'd32, 32'h44332211, 1'b0, 32'h0,        4'd2},  // R2 word write
    '{1'b0, 2'd2, 1'b0, 1'b0, 10'd32, 32'h0,        1'b1, 32'h44332211, 4'd2},  // R2 lane order
    '{1'b0, 2'd0, 1'b0, 1'b0, 10'd33, 32'h0,        1'b1, 32'h22,       4'd2},
    '{1'b0, 2'd0, 1'b1, 1'b0, 10'd33, 32'h0,        1'b1, 32'h44,       4'd5},  // R5
    '{1'b1, 2'd0, 1'b1, 1'b0, 10'd34, 32'h60,       1'b0, 32'h0,        4'd6},  // R6
    '{1'b0, 2'd0, 1'b0, 1'b0, 10'd34, 32'h0,        1'b1, 32'hB0,       4'd6},
    '{1'b0, 2'd0, 1'b1, 1'b0, 10'd34, 32'h0,        1'b1, 32'h60,       4'd5},
    '{1'b1, 2'd2, 1'b0, 1'b0, 10'd40, 32'h8899AABB, 1'b0, 32'h0,        4'd3},  // R3
    '{1'b0, 2'd2, 1'b1, 1'b0, 10'd40, 32'h0,        1'b1, 32'h0,        4'd4},  // R4 hidden read
    '{1'b1, 2'd0, 1'b1, 1'b0, 10'd41, 32'hFF,       1'b0, 32'h0,        4'd4},  // R4 ignored write
    '{1'b0, 2'd0, 1'b0, 1'b0, 10'd41, 32'h0,        1'b1, 32'hAA,       4'd4},
    '{1'b0, 2'd0, 1'b1, 1'b1, 10'd41, 32'h0,        1'b1, 32'hAA,       4'd3},  // R3 security off
    '{1'b1, 2'd0, 1'b1, 1'b1, 10'd42, 32'h12,       1'b0, 32'h0,        4'd3},
    '{1'b0, 2'd0, 1'b0, 1'b0, 10'd42, 32'h0,        1'b1, 32'h12,       4'd3},
    '{1'b1, 2'd2, 1'b0, 1'b0, 10'd48, 32'h04030201, 1'b0, 32'h0,        4'd10},
    '{1'b1, 2'd2, 1'b1, 1'b0, 10'd48, 32'hFEDCBA98, 1'b0, 32'h0,        4'd10}, // R10 mixed lanes
    '{1'b0, 2'd2, 1'b0, 1'b0, 10'd48, 32'h0,        1'b1, 32'hFF03DD01, 4'd10},
    '{1'b0, 2'd2, 1'b1, 1'b0, 10'd48, 32'h0,        1'b1, 32'hFE00BA00, 4'd10},
    '{1'b0, 2'd1, 1'b0, 1'b0, 10'd32, 32'h0,        1'b1, 32'h0,        4'd9},  // R9 half read
    '{1'b1, 2'd1, 1'b0, 1'b0, 10'd32, 32'hFFFF,     1'b0, 32'h0,        4'd9},
    '{1'b0, 2'd0, 1'b0, 1'b0, 10'd32, 32'h0,        1'b1, 32'h11,       4'd9},
    '{1'b1, 2'd0, 1'b0, 1'b0, 10'd5,  32'h77,       1'b0, 32'h0,        4'd8},  // R8 banked
    '{1'b0, 2'd0, 1'b0, 1'b0, 10'd5,  32'h0,        1'b1, 32'h0,        4'd8},
    '{1'b0, 2'd0, 1'b0, 1'b0, 10'd62, 32'h0,        1'b1, 32'h0,        4'd8},  // R8 beyond count
    '{1'b1, 2'd0, 1'b0, 1'b0, 10'd60, 32'h5A,       1'b0, 32'h0,        4'd7},
    '{1'b1, 2'd0, 1'b0, 1'b0, 10'd61, 32'h6B,       1'b0, 32'h0,        4'd7},
    '{1'b1, 2'd2, 1'b0, 1'b0, 10'd60, 32'hDEADBEEF, 1'b0, 32'h0,        4'd7},  // R7 straddle drop
    '{1'b0, 2'd2, 1'b0, 1'b0, 10'd60, 32'h0,        1'b1, 32'h00006B5A, 4'd7},
    '{1'b1, 2'd2, 1'b0, 1'b0, 10'd56, 32'h0D0C0B0A, 1'b0, 32'h0,        4'd7},
    '{1'b0, 2'd2, 1'b0, 1'b0, 10'd56, 32'h0,        1'b1, 32'h0D0C0B0A, 4'd7},
    '{1'b0, 2'd2, 1'b0, 1'b0, 10'd28, 32'h0,        1'b1, 32'h0,        4'd7},
    '{1'b1, 2'd2, 1'b0, 1'b0, 10'd33, 32'hFFFFFFFF, 1'b0, 32'h0,        4'd9},  // R9 misaligned
    '{1'b0, 2'd0, 1'b0, 1'b0, 10'd33, 32'h0,        1'b1, 32'h22,       4'd9},
    '{1'b0, 2'd3, 1'b0, 1'b0, 10'd32, 32'h0,        1'b1, 32'h0,        4'd9},
    '{1'b0, 2'd2, 1'b0, 1'b0, 10'd33, 32'h0,        1'b1, 32'h0,        4'd9}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic doReq(input vec_t v);
    @(negedge clk);
    check("R11 idle response", {31'h0, rspValid}, 32'h0);
    reqValid  = 1'b1;
    reqWrite  = v.wr;
    reqSize   = v.size;
    reqAddr   = v.addr;
    reqNonSec = v.ns;
    secDisable = v.sd;
    reqWdata  = v.wdata;
    @(negedge clk);
    reqValid  = 1'b0;
    check("R11 response valid", {31'h0, rspValid}, 32'h1);
    if (v.chk) check($sformatf("R%0d read data", v.req), rspRdata, v.exp);
    secDisable = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqSize = 2'd0;
    reqAddr = '0; reqNonSec = 1'b0; reqWdata = '0; secDisable = 1'b0;
    groupBits = GRP;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset priorities", {31'h0, (prioFlat == '0)}, 32'h1);
    check("R1 reset response", {31'h0, rspValid}, 32'h0);

    for (int i = 0; i < NV; i++) doReq(TBL[i]);

    // R11 and R2: stored bytes are visible on the priority output
    check("R11 output entry 49", {24'h0, prioFlat[8*49 +: 8]}, 32'hDD);
    check("R2 output entry 60", {24'h0, prioFlat[8*60 +: 8]}, 32'h5A);
    check("R8 output entry 5", {24'h0, prioFlat[8*5 +: 8]}, 32'h00);
    check("R4 output entry 41", {24'h0, prioFlat[8*41 +: 8]}, 32'hAA);

    // R1: reset in the middle of operation clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", {31'h0, (prioFlat == '0)}, 32'h1);
    check("R1 mid-run response", {31'h0, rspValid}, 32'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule